// File: doc/BRIEF.md
# SDRAM Single-Bank Command Legality Tracker

This block samples the four active-low SDRAM command strobes on every rising clock edge and turns them into a decoded command. It follows one bank through its life cycle: idle, opening a row, row open, read burst, write burst, closing, and column access with automatic close. It also raises a one-cycle flag whenever a command arrives that the bank's current state does not permit. Row-open delay, close delay and burst length come in as cycle counts on input ports. Each timed state is measured by a single reloadable down-counter.

A monitor or a controller's self-check instantiates the tracker beside the command bus. It watches `state_o` to see where the bank stands and `illegal_o` to catch protocol violations. A command is judged only when the clock enable was high on the previous edge and is high on the current one. Otherwise the edge counts as a no-op.

State machine. States: IDLE, OPENING, OPEN, READ, WRITE, CLOSING, READ_AP, WRITE_AP. Transitions:
- IDLE goes to OPENING on ACTIVE.
- OPENING goes to OPEN when the row delay expires.
- OPEN goes to READ or WRITE on a column command without auto close. It goes to READ_AP or WRITE_AP on a column command with auto close, and to CLOSING on PRECHARGE.
- READ and WRITE move between each other on column commands and restart on a repeat of their own command. Both go to CLOSING on PRECHARGE and back to OPEN when the burst count expires. READ also goes back to OPEN on BURST TERMINATE.
- CLOSING, READ_AP and WRITE_AP go to IDLE when their count expires.

Top module: `bank_cmd_tracker`

## Requirements
- R1: `cmd_o` decodes the strobes combinationally as {cs,ras,cas,we}. Chip select high gives 0 (DESELECT). With chip select low, ras/cas/we decode as follows: HHH=1 (NOP), LHH=2 (ACTIVE), LLH=3 (AUTO REFRESH), LLL=4 (MODE LOAD), HLH=5 (READ), HLL=6 (WRITE), LHL=7 (PRECHARGE), HHL=8 (BURST TERMINATE).
- R2: DESELECT and NOP are legal in every state, never raise the flag, and leave a running count undisturbed.
- R3: `state_o` encodes the states as IDLE=0, OPENING=1, OPEN=2, READ=3, WRITE=4, CLOSING=5, READ_AP=6, WRITE_AP=7. In IDLE, ACTIVE, AUTO REFRESH and MODE LOAD are legal. AUTO REFRESH and MODE LOAD leave the bank in IDLE.
- R4: ACTIVE puts the bank in OPENING for exactly `t_rcd_i` cycles, after which it enters OPEN.
- R5: In OPEN, READ, WRITE and PRECHARGE are legal.
- R6: In READ, READ (burst restart), WRITE, PRECHARGE (truncation into CLOSING) and BURST TERMINATE (back to OPEN) are legal.
- R7: In WRITE, READ, WRITE (burst restart) and PRECHARGE (truncation into CLOSING) are legal.
- R8: PRECHARGE puts the bank in CLOSING for exactly `t_rp_i` cycles, after which it enters IDLE.
- R9: A READ or WRITE issued with `auto_close_i` high enters READ_AP or WRITE_AP. The bank stays there for `burst_len_i + t_rp_i` cycles, then enters IDLE.
- R10: A READ or WRITE with `auto_close_i` low holds READ or WRITE for `burst_len_i` cycles, then returns to OPEN unless another command interrupts it.
- R11: Any command other than DESELECT or NOP that the current state does not permit raises `illegal_o` for one cycle, starting on the edge after it was sampled. It changes neither the state nor a running count. OPENING, CLOSING, READ_AP and WRITE_AP permit no such command.
- R12: When `cke_prev_i` or `cke_i` is low, the command is treated as a NOP: no flag and no state change other than timer expiry.
- R13: After reset, `state_o` is IDLE and `illegal_o` is low.
- R14: A value of 0 on `t_rcd_i`, `t_rp_i` or `burst_len_i` behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_prev_i | input | 1 | Clock enable at the previous edge |
| cke_i | input | 1 | Clock enable at the current edge |
| cs_ni | input | 1 | Chip select strobe, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable strobe, active low |
| auto_close_i | input | 1 | Auto precharge request on column commands |
| t_rcd_i | input | TW | Row-open delay in cycles |
| t_rp_i | input | TW | Close delay in cycles |
| burst_len_i | input | TW | Burst length in cycles |
| cmd_o | output | 4 | Decoded command code |
| state_o | output | 3 | Bank state code |
| illegal_o | output | 1 | One-cycle illegal command flag |

## Verification
The bench drives the bank into each of the eight states and applies every strobe pattern with both auto-close settings. It then follows the bank through the next cycles and compares the results with a cycle-counting model. This exposes a tracker that accepts a command in a transient state, for example one that lets ACTIVE through during CLOSING, which would show up as an early OPENING. It also exposes off-by-one counters, which would leave OPENING, CLOSING or a burst one cycle early or late. Further targets are PRECHARGE truncation of a burst, BURST TERMINATE being accepted in WRITE, and clock-enable gating that still raises the flag. A final pass with zero timing inputs catches a counter that wraps around instead of treating zero as one.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_REF   = 4'd3,
        CMD_MODE  = 4'd4,
        CMD_RD    = 4'd5,
        CMD_WR    = 4'd6,
        CMD_PRE   = 4'd7,
        CMD_BST   = 4'd8
    } bank_cmd_e;

    typedef enum logic [2:0] {
        BS_IDLE     = 3'd0,
        BS_OPENING  = 3'd1,
        BS_OPEN     = 3'd2,
        BS_READ     = 3'd3,
        BS_WRITE    = 3'd4,
        BS_CLOSING  = 3'd5,
        BS_READ_AP  = 3'd6,
        BS_WRITE_AP = 3'd7
    } bank_state_e;

endpackage

// File: rtl/bank_cmd_decode.sv
module bank_cmd_decode
    import bank_trk_pkg::*;
(
    input  logic      cs_ni,
    input  logic      ras_ni,
    input  logic      cas_ni,
    input  logic      we_ni,
    output bank_cmd_e cmd_o
);

    always_comb begin
        if (cs_ni) begin
            cmd_o = CMD_DESEL;
        end else begin
            unique case ({ras_ni, cas_ni, we_ni})
                3'b111:  cmd_o = CMD_NOP;
                3'b011:  cmd_o = CMD_ACT;
                3'b001:  cmd_o = CMD_REF;
                3'b000:  cmd_o = CMD_MODE;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = CMD_PRE;
                default: cmd_o = CMD_BST;
            endcase
        end
    end

endmodule

// File: rtl/bank_cmd_rules.sv
module bank_cmd_rules
    import bank_trk_pkg::*;
(
    input  bank_state_e state_i,
    input  bank_cmd_e   cmd_i,
    output logic        legal_o
);

    logic idle_cmd;
    logic by_state;

    assign idle_cmd = (cmd_i == CMD_DESEL) || (cmd_i == CMD_NOP);

    always_comb begin
        unique case (state_i)
            BS_IDLE:  by_state = (cmd_i == CMD_ACT) || (cmd_i == CMD_REF) || (cmd_i == CMD_MODE);
            BS_OPEN:  by_state = (cmd_i == CMD_RD) || (cmd_i == CMD_WR) || (cmd_i == CMD_PRE);
            BS_READ:  by_state = (cmd_i == CMD_RD) || (cmd_i == CMD_WR) || (cmd_i == CMD_PRE)
                                 || (cmd_i == CMD_BST);
            BS_WRITE: by_state = (cmd_i == CMD_RD) || (cmd_i == CMD_WR) || (cmd_i == CMD_PRE);
            default:  by_state = 1'b0;
        endcase
    end

    assign legal_o = idle_cmd || by_state;

endmodule

// File: rtl/bank_cycle_timer.sv
module bank_cycle_timer #(
    parameter int CW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R10: without a reload the count only steps down by one
    a_r10_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R14: a load never leaves a value above the loaded one
    a_r14_load_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && load_val_i != '0) |=> (cnt_q < $past(load_val_i)));

endmodule

// File: rtl/bank_cmd_tracker.sv
module bank_cmd_tracker
    import bank_trk_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cke_prev_i,
    input  logic          cke_i,
    input  logic          cs_ni,
    input  logic          ras_ni,
    input  logic          cas_ni,
    input  logic          we_ni,
    input  logic          auto_close_i,
    input  logic [TW-1:0] t_rcd_i,
    input  logic [TW-1:0] t_rp_i,
    input  logic [TW-1:0] burst_len_i,
    output logic [3:0]    cmd_o,
    output logic [2:0]    state_o,
    output logic          illegal_o
);

    localparam int CW = TW + 1;

    bank_cmd_e     cmd;
    bank_state_e   state_q, state_n;
    logic          legal, gate, take, exec, bad;
    logic          tload, expired, timed;
    logic [CW-1:0] tval, rcd_eff, rp_eff, bl_eff, ap_len;
    logic          illegal_q;

    bank_cmd_decode u_decode (
        .cs_ni  (cs_ni),
        .ras_ni (ras_ni),
        .cas_ni (cas_ni),
        .we_ni  (we_ni),
        .cmd_o  (cmd)
    );

    bank_cmd_rules u_rules (
        .state_i (state_q),
        .cmd_i   (cmd),
        .legal_o (legal)
    );

    bank_cycle_timer #(.CW(CW)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tload),
        .load_val_i (tval),
        .expired_o  (expired)
    );

    assign rcd_eff = (t_rcd_i == '0)     ? CW'(1) : CW'(t_rcd_i);
    assign rp_eff  = (t_rp_i == '0)      ? CW'(1) : CW'(t_rp_i);
    assign bl_eff  = (burst_len_i == '0) ? CW'(1) : CW'(burst_len_i);
    assign ap_len  = bl_eff + rp_eff;

    assign gate  = cke_prev_i && cke_i;
    assign take  = gate && (cmd != CMD_DESEL) && (cmd != CMD_NOP);
    assign exec  = take && legal;
    assign bad   = take && !legal;
    assign timed = (state_q != BS_IDLE) && (state_q != BS_OPEN);

    // next-state and timer load
    always_comb begin
        state_n = state_q;
        tload   = 1'b0;
        tval    = '0;
        if (exec) begin
            unique case (cmd)
                CMD_ACT: begin
                    state_n = BS_OPENING;
                    tload   = 1'b1;
                    tval    = rcd_eff;
                end
                CMD_RD, CMD_WR: begin
                    tload = 1'b1;
                    if (auto_close_i) begin
                        state_n = (cmd == CMD_RD) ? BS_READ_AP : BS_WRITE_AP;
                        tval    = ap_len;
                    end else begin
                        state_n = (cmd == CMD_RD) ? BS_READ : BS_WRITE;
                        tval    = bl_eff;
                    end
                end
                CMD_PRE: begin
                    state_n = BS_CLOSING;
                    tload   = 1'b1;
                    tval    = rp_eff;
                end
                CMD_BST: state_n = BS_OPEN;
                default: state_n = state_q;
            endcase
        end else if (timed && expired) begin
            unique case (state_q)
                BS_OPENING, BS_READ, BS_WRITE: state_n = BS_OPEN;
                default:                       state_n = BS_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= BS_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= bad;
        end
    end

    assign cmd_o     = cmd;
    assign state_o   = state_q;
    assign illegal_o = illegal_q;

    // R3: IDLE can only stay or start opening
    a_r3_idle_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == BS_IDLE) |=> (state_q == BS_IDLE || state_q == BS_OPENING));

    // R4: OPENING can only stay or reach OPEN
    a_r4_opening_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == BS_OPENING) |=> (state_q == BS_OPENING || state_q == BS_OPEN));

    // R8: CLOSING can only stay or reach IDLE
    a_r8_closing_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == BS_CLOSING) |=> (state_q == BS_CLOSING || state_q == BS_IDLE));

    // R9: auto-close states end in IDLE
    a_r9_ap_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == BS_READ_AP || state_q == BS_WRITE_AP) |=>
        (state_q == $past(state_q) || state_q == BS_IDLE));

    // R11: a flagged command in an untimed state leaves the state alone
    a_r11_illegal_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (illegal_o && ($past(state_q) == BS_IDLE || $past(state_q) == BS_OPEN)) |->
        $stable(state_q));

    // R12: gated clock enable never produces a flag
    a_r12_cke_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cke_prev_i && cke_i) |=> !illegal_o);

endmodule

// File: tb/test_bank_cmd_tracker.sv
module test_bank_cmd_tracker;

    logic       clk_i = 1'b0;
    logic       rst_ni, cke_prev_i, cke_i, cs_ni, ras_ni, cas_ni, we_ni, auto_close_i;
    logic [3:0] t_rcd_i, t_rp_i, burst_len_i;
    logic [3:0] cmd_o;
    logic [2:0] state_o;
    logic       illegal_o;

    int checks = 0;
    int errors = 0;
    int m_state = 0;
    int m_rem   = 0;
    string tag_ovr = "";

    localparam logic [3:0] S_NOP = 4'b0111;
    localparam logic [3:0] S_ACT = 4'b0011;
    localparam logic [3:0] S_RD  = 4'b0101;
    localparam logic [3:0] S_WR  = 4'b0100;
    localparam logic [3:0] S_PRE = 4'b0010;

    always #5 clk_i = ~clk_i;

    bank_cmd_tracker #(.TW(4)) i_bank_cmd_tracker (
        .clk_i(clk_i), .rst_ni(rst_ni), .cke_prev_i(cke_prev_i), .cke_i(cke_i),
        .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
        .auto_close_i(auto_close_i), .t_rcd_i(t_rcd_i), .t_rp_i(t_rp_i),
        .burst_len_i(burst_len_i), .cmd_o(cmd_o), .state_o(state_o), .illegal_o(illegal_o)
    );

    function automatic int dec(logic [3:0] s);
        if (s[3]) return 0;
        case (s[2:0])
            3'b111: return 1;
            3'b011: return 2;
            3'b001: return 3;
            3'b000: return 4;
            3'b101: return 5;
            3'b100: return 6;
            3'b010: return 7;
            default: return 8;
        endcase
    endfunction

    function automatic bit allowed(int st, int c);
        if (c <= 1) return 1;
        case (st)
            0: return (c == 2 || c == 3 || c == 4);
            2: return (c == 5 || c == 6 || c == 7);
            3: return (c == 5 || c == 6 || c == 7 || c == 8);
            4: return (c == 5 || c == 6 || c == 7);
            default: return 0;
        endcase
    endfunction

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic string state_tag(int st);
        case (st)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic advance();
        if (m_state != 0 && m_state != 2) begin
            if (m_rem == 0) m_state = (m_state <= 4) ? 2 : 0;
            else m_rem--;
        end
    endtask

    // called at a negedge; returns at the next negedge after checking
    task automatic step(logic [3:0] s, logic a, logic kp, logic kc);
        int c;
        int exp_ill;
        string tag;
        {cs_ni, ras_ni, cas_ni, we_ni} = s;
        auto_close_i = a;
        cke_prev_i   = kp;
        cke_i        = kc;
        #1;
        c = dec(s);
        check("R1", int'(cmd_o), c, "command code");
        exp_ill = 0;
        tag = state_tag(m_state);
        if (kp && kc && c > 1) begin
            if (!allowed(m_state, c)) begin
                exp_ill = 1;
                tag = "R11";
                advance();
            end else begin
                case (c)
                    2: begin m_state = 1; m_rem = eff(int'(t_rcd_i)) - 1; end
                    5, 6: begin
                        if (a) begin
                            m_state = (c == 5) ? 6 : 7;
                            m_rem   = eff(int'(burst_len_i)) + eff(int'(t_rp_i)) - 1;
                        end else begin
                            m_state = (c == 5) ? 3 : 4;
                            m_rem   = eff(int'(burst_len_i)) - 1;
                        end
                    end
                    7: begin m_state = 5; m_rem = eff(int'(t_rp_i)) - 1; end
                    8: m_state = 2;
                    default: ;
                endcase
            end
        end else begin
            if (!(kp && kc)) tag = "R12";
            else if (m_state == 3 || m_state == 4) tag = "R10";
            else tag = "R2";
            advance();
        end
        if (tag_ovr != "") tag = tag_ovr;
        @(negedge clk_i);
        check(tag, int'(state_o), m_state, "state");
        check(tag, int'(illegal_o), exp_ill, "illegal flag");
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        {cs_ni, ras_ni, cas_ni, we_ni} = S_NOP;
        auto_close_i = 1'b0; cke_prev_i = 1'b1; cke_i = 1'b1;
        @(negedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        m_state = 0; m_rem = 0;
        check("R13", int'(state_o), 0, "reset state");
        check("R13", int'(illegal_o), 0, "reset flag");
    endtask

    task automatic prefix(int st);
        if (st == 0) return;
        step(S_ACT, 1'b0, 1'b1, 1'b1);
        if (st == 1) return;
        for (int i = 0; i < eff(int'(t_rcd_i)); i++) step(S_NOP, 1'b0, 1'b1, 1'b1);
        case (st)
            3: step(S_RD, 1'b0, 1'b1, 1'b1);
            4: step(S_WR, 1'b0, 1'b1, 1'b1);
            5: step(S_PRE, 1'b0, 1'b1, 1'b1);
            6: step(S_RD, 1'b1, 1'b1, 1'b1);
            7: step(S_WR, 1'b1, 1'b1, 1'b1);
            default: ;
        endcase
        check(state_tag(st), int'(state_o), st, "setup state");
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_rcd_i = 4'd2; t_rp_i = 4'd3; burst_len_i = 4'd2;
        @(negedge clk_i);
        do_reset();

        // sweep: every state x every strobe pattern x auto-close
        for (int st = 0; st < 8; st++) begin
            for (int code = 0; code < 32; code++) begin
                do_reset();
                prefix(st);
                step(code[3:0], code[4], 1'b1, 1'b1);
                for (int k = 0; k < 7; k++) step(S_NOP, 1'b0, 1'b1, 1'b1);
            end
        end

        // R12: clock-enable gating in IDLE and OPEN
        do_reset();
        step(S_ACT, 1'b0, 1'b0, 1'b1);
        step(S_ACT, 1'b0, 1'b1, 1'b0);
        step(S_PRE, 1'b0, 1'b0, 1'b0);
        prefix(2);
        step(S_ACT, 1'b0, 1'b1, 1'b0);
        step(S_NOP, 1'b0, 1'b1, 1'b1);

        // R10: longer bursts, restart and truncation
        burst_len_i = 4'd5; t_rp_i = 4'd4; t_rcd_i = 4'd3;
        do_reset();
        prefix(3);
        step(S_NOP, 1'b0, 1'b1, 1'b1);
        step(S_RD, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 6; k++) step(S_NOP, 1'b0, 1'b1, 1'b1);
        step(S_WR, 1'b0, 1'b1, 1'b1);
        step(S_NOP, 1'b0, 1'b1, 1'b1);
        step(S_PRE, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 5; k++) step(S_NOP, 1'b0, 1'b1, 1'b1);

        // R14: zero timing inputs behave as one
        tag_ovr = "R14";
        t_rcd_i = 4'd0; t_rp_i = 4'd0; burst_len_i = 4'd0;
        do_reset();
        step(S_ACT, 1'b0, 1'b1, 1'b1);
        step(S_NOP, 1'b0, 1'b1, 1'b1);
        step(S_RD, 1'b0, 1'b1, 1'b1);
        step(S_NOP, 1'b0, 1'b1, 1'b1);
        step(S_WR, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) step(S_NOP, 1'b0, 1'b1, 1'b1);
        step(S_ACT, 1'b0, 1'b1, 1'b1);
        step(S_NOP, 1'b0, 1'b1, 1'b1);
        step(S_PRE, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 2; k++) step(S_NOP, 1'b0, 1'b1, 1'b1);
        tag_ovr = "";

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule